// File: doc/BRIEF.md
# Streaming Min-Max Scaled Histogram

This block counts how often each value range occurs in a slow stream of samples, building a 50-bin histogram. Software or a neighbouring block sets a lower and an upper bound. Each accepted sample gets a bin index: its offset above the lower bound is multiplied by the number of bins and then divided by the width of the range. Samples below the range land in the first bin and samples at or above the top land in the last bin. Each bin holds a saturating count that grows from frame to frame until a clear command wipes the table.

Samples arrive from a source that may present data at any time. The block takes at most one of them per video frame, and only while the vertical-retrace input is high. A display consumer can ask for the whole table at any point. The block then streams every bin count, lowest bin first, one per cycle. A readout request that arrives while a bin update is under way waits until that update is done. No samples are taken while the table is being streamed or cleared.

Top module: `minmax_hist`

## Requirements
- R1: After the active-low asynchronous reset `rstN`, `outValid` and `busy` are low and every bin count reads back as zero.
- R2: A sample `s` with `boundLo <= s < boundHi` increments bin floor((s - boundLo) * 50 / (boundHi - boundLo)), where bins are numbered 0 to 49.
- R3: A sample below `boundLo` increments bin 0. A sample at or above `boundHi` increments bin 49.
- R4: While `retrace` stays high, only the first cycle with `sampleValid` high (with the block idle) is counted. Further valid samples are ignored until `retrace` has gone low and then high again.
- R5: A sample presented while `retrace` is low is ignored.
- R6: Counts accumulate across frames. Each bin saturates at 2^COUNT_W - 1 (COUNT_W defaults to 16) instead of wrapping.
- R7: A one-cycle `readReq` pulse taken while the block is idle makes `outValid` rise one cycle later. It then stays high for 50 consecutive cycles with `outBin` going 0, 1, ... 49, `outCount` giving that bin's count, and `outLast` high only with bin 49.
- R8: A `readReq` that arrives while a bin update is in progress is remembered and served after the update, so the readout includes that sample. Samples presented during a readout are ignored.
- R9: A one-cycle `clearReq` pulse sets every bin to zero. `busy` rises the cycle after the request is taken and stays high for exactly 50 cycles. If a clear and a readout are both waiting, the clear runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Sample present on sampleData |
| sampleData | input | SAMPLE_W | Unsigned sample value |
| boundLo | input | SAMPLE_W | Lower bound of the binned range |
| boundHi | input | SAMPLE_W | Upper bound (exclusive) of the binned range |
| retrace | input | 1 | High during the vertical-retrace window of a frame |
| clearReq | input | 1 | Pulse: zero all bins |
| readReq | input | 1 | Pulse: stream all bins out |
| outValid | output | 1 | outBin/outCount carry a readout item |
| outBin | output | clog2(BINS) | Bin index of the current item |
| outCount | output | COUNT_W | Count held in that bin |
| outLast | output | 1 | Marks the item for bin 49 |
| busy | output | 1 | Clear sweep in progress |

## Verification
A sample taken at one clock edge reaches its bin at the next edge, so every frame the bench drives leaves the retrace window open for two more cycles before readout can begin. A readout item for bin k is due k+1 cycles after the edge that takes the request, and the scoreboard pops the expected item only on cycles where `outValid` is high, so a missing, extra or out-of-order item is caught. When a read request lands during an update it is served one cycle later, and the queue expects exactly that order. For a clear, `busy` is sampled on each falling edge starting with the first cycle after the request edge, and must read high exactly 50 times.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_UPDATE,
    ST_READ,
    ST_CLEAR
  } hist_state_e;

  typedef struct packed {
    logic captureEn;
    logic updateEn;
    logic clearEn;
    logic readEn;
  } hist_ctrl_t;

endpackage

// File: rtl/hist_binmap.sv
module hist_binmap #(
  parameter int SAMPLE_W = 18,
  parameter int BINS     = 50
) (
  input  logic [SAMPLE_W-1:0]        sample,
  input  logic [SAMPLE_W-1:0]        lo,
  input  logic [SAMPLE_W-1:0]        hi,
  output logic [$clog2(BINS)-1:0]    binIdx
);

  localparam int IDX_W = $clog2(BINS);
  localparam int MUL_W = $clog2(BINS + 1);
  localparam int PW    = SAMPLE_W + MUL_W;

  logic [SAMPLE_W-1:0] offset;
  logic [SAMPLE_W-1:0] span;
  logic [SAMPLE_W-1:0] divisor;
  logic [PW-1:0]       prod;
  logic [PW-1:0]       quot;

  always_comb begin
    offset  = sample - lo;
    span    = hi - lo;
    divisor = (span == '0) ? SAMPLE_W'(1) : span;
    prod    = PW'(offset) * PW'(BINS);
    quot    = prod / PW'(divisor);
    if (sample < lo)
      binIdx = '0;
    else if (sample >= hi)
      binIdx = IDX_W'(BINS - 1);
    else
      binIdx = IDX_W'(quot);
  end

  // R2 / R3: whatever the bounds, the index names a real bin
  always_comb begin
    a_r2_bin_range: assert (int'(binIdx) < BINS);
  end

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int BINS = 50
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic                     retrace,
  input  logic                     clearReq,
  input  logic                     readReq,
  output hist_ctrl_t               strobes,
  output logic [$clog2(BINS)-1:0]  idx,
  output logic                     busy
);

  localparam int IDX_W = $clog2(BINS);

  hist_state_e state;
  logic readPend;
  logic clearPend;
  logic taken;
  logic wantClear;
  logic wantRead;
  logic startClear;
  logic startRead;
  logic acceptOk;
  logic lastIdx;

  always_comb begin
    wantClear  = clearReq | clearPend;
    wantRead   = readReq | readPend;
    startClear = (state == ST_IDLE) && wantClear;
    startRead  = (state == ST_IDLE) && !wantClear && wantRead;
    acceptOk   = (state == ST_IDLE) && !wantClear && !wantRead &&
                 retrace && sampleValid && !taken;
    lastIdx    = (idx == IDX_W'(BINS - 1));
    strobes.captureEn = acceptOk;
    strobes.updateEn  = (state == ST_UPDATE);
    strobes.clearEn   = (state == ST_CLEAR);
    strobes.readEn    = (state == ST_READ);
    busy              = (state == ST_CLEAR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      idx       <= '0;
      readPend  <= 1'b0;
      clearPend <= 1'b0;
      taken     <= 1'b0;
    end else begin
      clearPend <= wantClear & ~startClear;
      readPend  <= wantRead & ~startRead;
      if (!retrace)
        taken <= 1'b0;
      else if (acceptOk)
        taken <= 1'b1;
      case (state)
        ST_IDLE: begin
          idx <= '0;
          if (startClear)
            state <= ST_CLEAR;
          else if (startRead)
            state <= ST_READ;
          else if (acceptOk)
            state <= ST_UPDATE;
        end
        ST_UPDATE: state <= ST_IDLE;
        ST_READ, ST_CLEAR: begin
          idx <= idx + 1'b1;
          if (lastIdx) begin
            state <= ST_IDLE;
            idx   <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4 / R5: a capture only ever happens on a valid sample inside retrace
  a_r4_accept_window: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |-> (retrace && sampleValid));

  // R9: once the clear sweep starts it does not stop after one cycle
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);

  // R8: a capture is always followed by the bin update, never by a readout
  a_r8_update_first: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureEn |=> (strobes.updateEn && !strobes.readEn));

endmodule

// File: rtl/hist_datapath.sv
module hist_datapath
  import hist_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int BINS     = 50,
  parameter int COUNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  hist_ctrl_t               strobes,
  input  logic [$clog2(BINS)-1:0]  idx,
  input  logic [SAMPLE_W-1:0]      sampleData,
  input  logic [SAMPLE_W-1:0]      boundLo,
  input  logic [SAMPLE_W-1:0]      boundHi,
  output logic                     outValid,
  output logic [$clog2(BINS)-1:0]  outBin,
  output logic [COUNT_W-1:0]       outCount,
  output logic                     outLast
);

  localparam int IDX_W = $clog2(BINS);
  localparam logic [COUNT_W-1:0] MAX_COUNT = '1;

  logic [SAMPLE_W-1:0] sampleReg;
  logic [IDX_W-1:0]    binIdx;
  logic [COUNT_W-1:0]  binCount [BINS];
  logic [COUNT_W-1:0]  readWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      sampleReg <= '0;
    else if (strobes.captureEn)
      sampleReg <= sampleData;
  end

  hist_binmap #(
    .SAMPLE_W (SAMPLE_W),
    .BINS     (BINS)
  ) u_binmap (
    .sample (sampleReg),
    .lo     (boundLo),
    .hi     (boundHi),
    .binIdx (binIdx)
  );

  for (genvar gi = 0; gi < BINS; gi++) begin : g_bin
    logic incHit;
    logic clrHit;
    assign incHit = strobes.updateEn && (binIdx == IDX_W'(gi));
    assign clrHit = strobes.clearEn && (idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        binCount[gi] <= '0;
      else if (clrHit)
        binCount[gi] <= '0;
      else if (incHit && (binCount[gi] != MAX_COUNT))
        binCount[gi] <= binCount[gi] + 1'b1;
    end

    // R6: a full bin stays full when hit again
    a_r6_saturate: assert property (@(posedge clk) disable iff (!rstN)
      (incHit && (binCount[gi] == MAX_COUNT)) |=> (binCount[gi] == MAX_COUNT));
  end

  always_comb begin
    readWord = '0;
    for (int k = 0; k < BINS; k++)
      if (idx == IDX_W'(k))
        readWord = binCount[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outBin   <= '0;
      outCount <= '0;
      outLast  <= 1'b0;
    end else begin
      outValid <= strobes.readEn;
      outLast  <= strobes.readEn && (idx == IDX_W'(BINS - 1));
      if (strobes.readEn) begin
        outBin   <= idx;
        outCount <= readWord;
      end
    end
  end

  // R7: consecutive readout items step through the bins in order
  a_r7_order: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outBin == $past(outBin) + 1'b1));

  // R7: the last marker only accompanies the top bin
  a_r7_last: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outValid && (outBin == IDX_W'(BINS - 1))));

endmodule

// File: rtl/minmax_hist.sv
module minmax_hist
  import hist_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int BINS     = 50,
  parameter int COUNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [SAMPLE_W-1:0]      sampleData,
  input  logic [SAMPLE_W-1:0]      boundLo,
  input  logic [SAMPLE_W-1:0]      boundHi,
  input  logic                     retrace,
  input  logic                     clearReq,
  input  logic                     readReq,
  output logic                     outValid,
  output logic [$clog2(BINS)-1:0]  outBin,
  output logic [COUNT_W-1:0]       outCount,
  output logic                     outLast,
  output logic                     busy
);

  hist_ctrl_t strobes;
  logic [$clog2(BINS)-1:0] idx;

  hist_ctrl #(
    .BINS (BINS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .retrace     (retrace),
    .clearReq    (clearReq),
    .readReq     (readReq),
    .strobes     (strobes),
    .idx         (idx),
    .busy        (busy)
  );

  hist_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .BINS     (BINS),
    .COUNT_W  (COUNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .idx        (idx),
    .sampleData (sampleData),
    .boundLo    (boundLo),
    .boundHi    (boundHi),
    .outValid   (outValid),
    .outBin     (outBin),
    .outCount   (outCount),
    .outLast    (outLast)
  );

endmodule

// File: tb/sim_minmax_hist.sv
`timescale 1ns/1ps
module sim_minmax_hist;

  localparam int SW   = 18;
  localparam int NB   = 50;
  localparam int CW   = 5;
  localparam int IW   = $clog2(NB);
  localparam int MAXC = (1 << CW) - 1;
  localparam int ITW  = IW + CW + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic [SW-1:0] boundLo = '0;
  logic [SW-1:0] boundHi = SW'(50);
  logic retrace = 1'b0;
  logic clearReq = 1'b0;
  logic readReq = 1'b0;
  logic outValid;
  logic [IW-1:0] outBin;
  logic [CW-1:0] outCount;
  logic outLast;
  logic busy;

  int total = 0;
  int bad = 0;
  int expCnt [NB];
  logic [ITW-1:0] expQ [$];
  string curTag = "R7";

  always #5 clk = ~clk;

  minmax_hist #(.SAMPLE_W(SW), .BINS(NB), .COUNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .boundLo(boundLo), .boundHi(boundHi), .retrace(retrace),
    .clearReq(clearReq), .readReq(readReq), .outValid(outValid),
    .outBin(outBin), .outCount(outCount), .outLast(outLast), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int binOf(input int s);
    int lo = int'(boundLo);
    int hi = int'(boundHi);
    if (s < lo) return 0;
    if (s >= hi) return NB - 1;
    return ((s - lo) * NB) / (hi - lo);
  endfunction

  function automatic void modelHit(input int s);
    int b = binOf(s);
    if (expCnt[b] < MAXC) expCnt[b]++;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, curTag, int'(outBin), -1);
      end else begin
        logic [ITW-1:0] e;
        e = expQ.pop_front();
        check(outBin == e[ITW-1 -: IW], curTag, int'(outBin), int'(e[ITW-1 -: IW]));
        check(outCount == e[CW:1], curTag, int'(outCount), int'(e[CW:1]));
        check(outLast == e[0], curTag, int'(outLast), int'(e[0]));
      end
    end
  end

  task automatic pushAll();
    for (int b = 0; b < NB; b++)
      expQ.push_back({IW'(b), CW'(expCnt[b]), (b == NB - 1)});
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && expQ.size() != 0; i++) @(negedge clk);
    check(expQ.size() == 0, curTag, expQ.size(), 0);
    @(negedge clk);
    check(outValid == 1'b0, curTag, int'(outValid), 0);
  endtask

  task automatic readAll(input string tag);
    curTag = tag;
    pushAll();
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    drain();
  endtask

  task automatic frame(input int s);
    retrace = 1'b1; sampleValid = 1'b1; sampleData = SW'(s);
    modelHit(s);
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    retrace = 1'b0;
    @(negedge clk);
  endtask

  task automatic doClear();
    int n = 0;
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    for (int i = 0; i < 100 && busy; i++) begin
      n++;
      @(negedge clk);
    end
    check(n == 50, "R9 busy length", n, 50);
    for (int b = 0; b < NB; b++) expCnt[b] = 0;
  endtask

  initial begin
    for (int b = 0; b < NB; b++) expCnt[b] = 0;
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    readAll("R1 zero bins");

    // R2 in-range mapping, span 500
    boundLo = SW'(100); boundHi = SW'(600);
    frame(100); frame(109); frame(110); frame(350); frame(599); frame(350);
    // R3 out-of-range clamps
    frame(5); frame(600); frame(9000);
    readAll("R2 R3 mapping");

    // R2 narrow span
    boundLo = SW'(1000); boundHi = SW'(1050);
    frame(1017); frame(1049); frame(1000);
    readAll("R2 narrow span");

    // R4: several valid samples inside one retrace window
    retrace = 1'b1; sampleValid = 1'b1; sampleData = SW'(1020);
    modelHit(1020);
    @(negedge clk); sampleData = SW'(1030);
    @(negedge clk); sampleData = SW'(1040);
    @(negedge clk); sampleData = SW'(1045);
    @(negedge clk); sampleValid = 1'b0; retrace = 1'b0;
    @(negedge clk);
    // R5: valid samples with retrace low
    sampleValid = 1'b1; sampleData = SW'(1001);
    repeat (4) @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    readAll("R4 R5 gating");

    // R8: read request during the update cycle
    retrace = 1'b1; sampleValid = 1'b1; sampleData = SW'(1033);
    modelHit(1033);
    @(negedge clk);
    sampleValid = 1'b0; readReq = 1'b1;
    curTag = "R8 held read";
    pushAll();
    @(negedge clk);
    readReq = 1'b0; retrace = 1'b0;
    drain();

    // R8: samples during readout are ignored
    curTag = "R8 read blocks";
    pushAll();
    readReq = 1'b1;
    @(negedge clk);
    readReq = 1'b0;
    repeat (5) @(negedge clk);
    retrace = 1'b1; sampleValid = 1'b1; sampleData = SW'(1002);
    repeat (3) @(negedge clk);
    retrace = 1'b0; sampleValid = 1'b0;
    drain();
    readAll("R8 nothing added");

    // R9 clear
    doClear();
    readAll("R9 cleared");

    // R6 accumulate and saturate
    boundLo = SW'(0); boundHi = SW'(50);
    for (int i = 0; i < 35; i++) frame(7);
    for (int i = 0; i < 3; i++) frame(20);
    readAll("R6 saturate");

    // R9 clear waits ahead of a simultaneous read
    clearReq = 1'b1; readReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0; readReq = 1'b0;
    for (int b = 0; b < NB; b++) expCnt[b] = 0;
    curTag = "R9 clear before read";
    check(busy == 1'b1, "R9 busy first", int'(busy), 1);
    pushAll();
    for (int i = 0; i < 60; i++) begin
      check(!(busy && outValid), "R9 no read in clear", int'(outValid), 0);
      @(negedge clk);
    end
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule